// File: doc/BRIEF.md
# Triggered Drift-Time Pipeline Readout

This block keeps a rolling record of fine-time hit samples for sixteen detector channels. A low-threshold discriminator signal is sampled at eight sub-phases of every 25 ns bunch clock. Each clock, the block receives one 128-bit vector of these samples, already aligned to that clock, and writes it into a circular latency buffer. The position in that buffer advances by one entry per clock.

When a level-1 accept arrives, the block picks out three consecutive bunch crossings that lie a programmed number of clocks in the past. That window holds 24 bins of about 3.1 ns per channel. The block copies the window into a small queue of pending accepts, together with a 4-bit trigger number. A serializer takes frames from the queue one at a time and shifts each frame out on a single line, most significant bit first. A busy output shows that frames are pending or being sent. A sticky overflow output shows that an accept had to be dropped because the queue was full.

Top module: `tdr_readout`

## Requirements
- R1: Synchronous active-high reset sets ser_out, busy and q_ovf to 0, clears the trigger number so that the first frame after reset carries 0, and empties the queue.
- R2: For an accept sampled at clock edge t with lat_cfg = L (valid range 3 to 2^AW-1), the window holds the sample vectors sampled at edges t-L, t-L+1 and t-L+2, counting only edges since reset.
- R3: Each frame is 391 bits long. The first three bits are 1, 0, 1, and the next four bits are the trigger number, most significant bit first.
- R4: The 384 data bits are sent channel 0 first and channel 15 last. Within a channel, the oldest crossing comes first. Within a crossing, the bins go from index 0 to index 7, where bin b of channel c is bit c*8+b of fine_smp.
- R5: The trigger number equals the count of accept strobes since reset, modulo 16. Dropped accepts also consume a number.
- R6: ser_out is 0 whenever no frame is being sent. An accept sampled at edge t while the block is idle makes the first header bit appear after edge t+1, and the last bit appear after edge t+391.
- R7: busy is 1 from the edge that takes an accept until the edge after the last bit of the last queued frame, and 0 otherwise.
- R8: Up to 4 accepts wait in the queue while a frame is being sent. Frames leave in accept order, each following the previous one with no gap.
- R9: An accept that arrives while 4 accepts are waiting, and no frame is taken from the queue at the same edge, is dropped and sets q_ovf. q_ovf then stays 1 until reset. An accept that arrives at the same edge as a take from a full queue is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| fine_smp | input | 128 | Fine-time samples, 8 bins for each of 16 channels; bit c*8+b is bin b of channel c |
| lat_cfg | input | 8 | Trigger latency in bunch clocks |
| l1_accept | input | 1 | Level-1 accept strobe |
| ser_out | output | 1 | Serial frame data |
| busy | output | 1 | Frames pending or in flight |
| q_ovf | output | 1 | Sticky dropped-accept flag |

## Verification
Two events can fall on the same edge: the serializer taking the next frame from a full queue, and a new accept being pushed into it. The bench provokes this by sending one accept followed by four back-to-back accepts. It then places a sixth accept exactly on the edge where the first frame ends, and a seventh accept one edge later. The sixth accept must be kept with q_ovf still 0. The seventh must be dropped and raise q_ovf. The frames that follow must carry trigger numbers that skip the dropped one.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    localparam int NCH  = 16;
    localparam int NBIN = 8;
    localparam int NWIN = 3;
    localparam int TCW  = 4;
    localparam int HDRW = 3;
    localparam logic [HDRW-1:0] HDR = 3'b101;

    localparam int SW   = NCH * NBIN;
    localparam int WINW = SW * NWIN;
    localparam int FRW  = HDRW + TCW + WINW;

    typedef logic [SW-1:0] slice_t;
    typedef logic [NWIN-1:0][SW-1:0] win_t;

    typedef struct packed {
        logic [TCW-1:0]  tnum;
        logic [WINW-1:0] bits;
    } acc_t;

    // Reorders a three-crossing window into send order, MSB first.
    function automatic logic [WINW-1:0] order_window(input win_t w);
        logic [WINW-1:0] r;
        r = '0;
        for (int ch = 0; ch < NCH; ch++)
            for (int x = 0; x < NWIN; x++)
                for (int b = 0; b < NBIN; b++)
                    r[WINW-1 - (ch*NWIN*NBIN + x*NBIN + b)] = w[x][ch*NBIN + b];
        return r;
    endfunction
endpackage

// File: rtl/tdr_lat_ram.sv
module tdr_lat_ram
    import tdr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  slice_t        samp,
    input  logic [AW-1:0] lat,
    output win_t          win
);
    localparam int DEPTH = 2 ** AW;

    slice_t        mem [DEPTH];
    logic [AW-1:0] wptr;

    always_ff @(posedge clk) begin
        if (rst) wptr <= '0;
        else     wptr <= wptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst) mem[wptr] <= samp;
    end

    for (genvar x = 0; x < NWIN; x++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra     = wptr - lat + AW'(x);
        assign win[x] = mem[ra];
    end
endmodule

// File: rtl/tdr_acc_fifo.sv
module tdr_acc_fifo
    import tdr_pkg::*;
#(
    parameter int QD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  acc_t din,
    input  logic pop,
    output acc_t dout,
    output logic empty,
    output logic ovf
);
    localparam int PW = (QD > 1) ? $clog2(QD) : 1;
    localparam int CW = $clog2(QD + 1);

    acc_t          q [QD];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_pop, take;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(QD - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty  = (cnt == '0);
    assign do_pop = pop && !empty;
    assign take   = push && ((cnt != CW'(QD)) || do_pop);
    assign dout   = q[rp];

    always_ff @(posedge clk) begin
        if (take) q[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (take)   wp <= step(wp);
            if (do_pop) rp <= step(rp);
            cnt <= cnt + CW'(take) - CW'(do_pop);
            if (push && !take) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/tdr_serial.sv
module tdr_serial
    import tdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic avail,
    input  acc_t din,
    output logic pop,
    output logic sout,
    output logic active
);
    localparam int CW = $clog2(FRW);

    logic [FRW-1:0] sh;
    logic [FRW-1:0] frame;
    logic [CW-1:0]  left;

    assign frame = {HDR, din.tnum, din.bits};
    assign pop   = avail && (!active || left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            left   <= '0;
            sout   <= 1'b0;
            active <= 1'b0;
        end else if (pop) begin
            sout   <= frame[FRW-1];
            sh     <= {frame[FRW-2:0], 1'b0};
            left   <= CW'(FRW - 1);
            active <= 1'b1;
        end else if (active) begin
            if (left == '0) begin
                active <= 1'b0;
                sout   <= 1'b0;
            end else begin
                sout <= sh[FRW-1];
                sh   <= {sh[FRW-2:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdr_readout.sv
module tdr_readout
    import tdr_pkg::*;
#(
    parameter int AW = 8,
    parameter int QD = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] fine_smp,
    input  logic [AW-1:0] lat_cfg,
    input  logic          l1_accept,
    output logic          ser_out,
    output logic          busy,
    output logic          q_ovf
);
    win_t           win;
    acc_t           q_in, q_out;
    logic           q_empty, q_pop, ser_active;
    logic [TCW-1:0] tcnt;

    tdr_lat_ram #(.AW(AW)) u_ram (
        .clk (clk),
        .rst (rst),
        .samp(fine_smp),
        .lat (lat_cfg),
        .win (win)
    );

    always_ff @(posedge clk) begin
        if (rst)            tcnt <= '0;
        else if (l1_accept) tcnt <= tcnt + 1'b1;
    end

    assign q_in.tnum = tcnt;
    assign q_in.bits = order_window(win);

    tdr_acc_fifo #(.QD(QD)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (l1_accept),
        .din  (q_in),
        .pop  (q_pop),
        .dout (q_out),
        .empty(q_empty),
        .ovf  (q_ovf)
    );

    tdr_serial u_ser (
        .clk   (clk),
        .rst   (rst),
        .avail (!q_empty),
        .din   (q_out),
        .pop   (q_pop),
        .sout  (ser_out),
        .active(ser_active)
    );

    assign busy = ser_active || !q_empty;
endmodule

// File: rtl/tdr_readout_chk.sv
module tdr_readout_chk
    import tdr_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           l1_accept,
    input logic           ser_out,
    input logic           busy,
    input logic           q_ovf,
    input logic           ser_active,
    input logic [TCW-1:0] tcnt
);
    // R9: the overflow flag holds once set
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        q_ovf |=> q_ovf);

    // R9: the overflow flag rises only after an accept
    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(q_ovf) |-> $past(l1_accept));

    // R6: line stays low with nothing to send
    p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_out);

    // R3: every frame opens with a 1
    p_hdr_first_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_active) |-> ser_out);

    // R7: an accept always leaves the block busy
    p_busy_after_acc_r7: assert property (@(posedge clk) disable iff (rst)
        l1_accept |=> busy);

    // R5: trigger number steps on every accept, dropped or not
    p_tnum_step_r5: assert property (@(posedge clk) disable iff (rst)
        l1_accept |=> tcnt == $past(tcnt) + 1'b1);

    // R5: trigger number holds without an accept
    p_tnum_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !l1_accept |=> $stable(tcnt));
endmodule

bind tdr_readout tdr_readout_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .l1_accept (l1_accept),
    .ser_out   (ser_out),
    .busy      (busy),
    .q_ovf     (q_ovf),
    .ser_active(ser_active),
    .tcnt      (tcnt)
);

// File: tb/tdr_readout_bench.sv
module tdr_readout_bench;
    import tdr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int QD         = 4;
    localparam int WDOG       = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] fine_smp = '0;
    logic [AW-1:0] lat_cfg = 8'd3;
    logic          l1_accept = 1'b0;
    logic          ser_out, busy, q_ovf;

    tdr_readout #(.AW(AW), .QD(QD)) u_tdr_readout (
        .clk      (clk),
        .rst      (rst),
        .fine_smp (fine_smp),
        .lat_cfg  (lat_cfg),
        .l1_accept(l1_accept),
        .ser_out  (ser_out),
        .busy     (busy),
        .q_ovf    (q_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int edge_no = 0;
    always @(posedge clk) edge_no <= edge_no + 1;

    int n_chk = 0, n_fail = 0, tn = 0;
    bit done = 0;
    logic [FRW-1:0] expq[$];
    logic [SW-1:0]  hist[int];

    task automatic chk(input bit ok, input string tag,
                       input logic [FRW-1:0] act, input logic [FRW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected frame built bit by bit in send order from the requirements.
    function automatic logic [FRW-1:0] mk(input logic [3:0] t, input logic [SW-1:0] s0,
                                          input logic [SW-1:0] s1, input logic [SW-1:0] s2);
        logic [FRW-1:0] r;
        logic [SW-1:0]  s;
        int p;
        p = FRW - 1;
        r[p] = 1'b1; p--;
        r[p] = 1'b0; p--;
        r[p] = 1'b1; p--;
        for (int i = 3; i >= 0; i--) begin r[p] = t[i]; p--; end
        for (int ch = 0; ch < NCH; ch++)
            for (int x = 0; x < 3; x++) begin
                s = (x == 0) ? s0 : (x == 1) ? s1 : s2;
                for (int b = 0; b < NBIN; b++) begin r[p] = s[ch*NBIN + b]; p--; end
            end
        return r;
    endfunction

    // Random samples, recorded by the edge that will take them.
    always @(negedge clk) begin
        logic [SW-1:0] v;
        v = {$urandom, $urandom, $urandom, $urandom};
        fine_smp = v;
        hist[edge_no + 1] = v;
    end

    // Frame collector and comparator.
    bit inf = 0;
    int nb = 0;
    logic [FRW-1:0] fr;
    always @(negedge clk) begin
        if (rst) begin
            inf = 0; nb = 0;
        end else if (!inf && ser_out) begin
            inf = 1; fr = '0; fr[0] = 1'b1; nb = 1;
        end else if (inf) begin
            fr = {fr[FRW-2:0], ser_out}; nb++;
        end
        if (inf && nb == FRW) begin
            inf = 0;
            if (expq.size() == 0) begin
                chk(0, "R8 unexpected frame", fr, '0);
            end else begin
                logic [FRW-1:0] e;
                e = expq.pop_front();
                chk(fr[FRW-1 -: 3] == 3'b101, "R3 header", FRW'(fr[FRW-1 -: 3]), FRW'(3'b101));
                chk(fr[FRW-4 -: 4] == e[FRW-4 -: 4], "R5 trigger number",
                    FRW'(fr[FRW-4 -: 4]), FRW'(e[FRW-4 -: 4]));
                chk(fr[WINW-1:0] == e[WINW-1:0], "R2 R4 window data and order",
                    FRW'(fr[WINW-1:0]), FRW'(e[WINW-1:0]));
            end
        end
    end

    task automatic pulse(input bit kept);
        int e, l;
        e = edge_no + 1;
        l = int'(lat_cfg);
        l1_accept = 1'b1;
        if (kept) expq.push_back(mk(4'(tn), hist[e-l], hist[e-l+1], hist[e-l+2]));
        tn++;
        @(negedge clk);
        l1_accept = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (edge_no > WDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", edge_no, WDOG);
            finish_run();
        end
    end

    initial begin
        int e0, k, len;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(ser_out == 0, "R1 ser_out in reset", FRW'(ser_out), '0);
        chk(busy == 0, "R1 busy in reset", FRW'(busy), '0);
        chk(q_ovf == 0, "R1 q_ovf in reset", FRW'(q_ovf), '0);
        rst = 1'b0;
        repeat (300) @(negedge clk);

        // R6 / R7 timing of a single idle accept
        lat_cfg = 8'd20;
        e0 = edge_no + 1;
        pulse(1);
        chk(busy == 1, "R7 busy after accept edge", FRW'(busy), FRW'(1));
        chk(ser_out == 0, "R6 line before first bit", FRW'(ser_out), '0);
        @(negedge clk);
        chk(ser_out == 1, "R6 first header bit one edge later", FRW'(ser_out), FRW'(1));
        while (edge_no < e0 + FRW) @(negedge clk);
        chk(busy == 1, "R7 busy during last bit", FRW'(busy), FRW'(1));
        @(negedge clk);
        chk(busy == 0, "R7 busy drops after last bit", FRW'(busy), '0);
        chk(ser_out == 0, "R6 line low when idle", FRW'(ser_out), '0);

        // Random bursts of up to five accepts (R2, R4, R5, R8)
        for (int bst = 0; bst < 8; bst++) begin
            wait_idle();
            lat_cfg = 8'(3 + $urandom % 253);
            len = 1 + $urandom % 5;
            for (int i = 0; i < len; i++) begin
                pulse(1);
                repeat ($urandom % 30) @(negedge clk);
            end
        end

        // R2 latency extremes
        wait_idle(); lat_cfg = 8'd3;   pulse(1);
        wait_idle(); lat_cfg = 8'd255; pulse(1);

        // R9 / R8 take and push on the same edge, then a drop
        wait_idle();
        lat_cfg = 8'd10;
        k = edge_no + 1;
        for (int i = 0; i < 5; i++) pulse(1);
        while (edge_no < k + FRW) @(negedge clk);
        pulse(1);
        chk(q_ovf == 0, "R9 accept with simultaneous take kept", FRW'(q_ovf), '0);
        pulse(0);
        chk(q_ovf == 1, "R9 accept into full queue dropped", FRW'(q_ovf), FRW'(1));
        wait_idle();
        chk(q_ovf == 1, "R9 overflow sticky", FRW'(q_ovf), FRW'(1));
        chk(expq.size() == 0, "R8 all queued frames sent", FRW'(expq.size()), '0);

        // R1 reset mid-life clears flag and trigger number
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(q_ovf == 0, "R1 q_ovf cleared", FRW'(q_ovf), '0);
        chk(busy == 0, "R1 busy cleared", FRW'(busy), '0);
        rst = 1'b0;
        tn = 0;
        expq.delete();
        repeat (300) @(negedge clk);
        lat_cfg = 8'd5;
        pulse(1);
        wait_idle();
        chk(expq.size() == 0, "R1 frame after reset received", FRW'(expq.size()), '0);

        finish_run();
    end
endmodule